// File: doc/BRIEF.md
# Zero-Suppressed Multichannel Timestamp Packer

This block sits behind a bank of time-to-digital front ends. It collects their results and turns them into a stream of timestamp words for a downstream FIFO. Every input runs on one system clock. The inputs are:

- 25 photon channels, each with a binary fine code;
- one laser-sync channel, also with a fine code;
- three reference channels that have coarse time only.

An event on a channel shows up as a change in that channel's toggle level. The block keeps a free-running coarse counter. It joins the coarse count with a 7-bit fine code to form a timestamp, `{coarse, fine}`.

Photon times are reported as start-stop values: the photon timestamp minus the timestamp of the most recent sync event. Reference times use the same scheme at coarse resolution only. The sync word carries the absolute sync timestamp.

The block takes a snapshot of the hit channels in a cycle. A two-state sequencer then emits one word per accepted handshake, in ascending channel order.

- **Zero suppression on:** only the channels that were hit are emitted.
- **Zero suppression off:** every channel is emitted, and each word's marker bit tells whether that channel was hit.

While the snapshot is still draining, `in_hold` is high and the edge detectors freeze. A toggle that arrives during a stall therefore waits and is captured once the snapshot has drained. Upstream must keep toggle levels and fine codes steady while `in_hold` is high.

Sequencer states and transitions:

| State | Meaning |
|---|---|
| ST_IDLE | No snapshot pending. |
| ST_EMIT | A snapshot is being emitted. |

| Transition | Condition |
|---|---|
| ST_IDLE → ST_EMIT | A hit is seen. |
| ST_EMIT → ST_EMIT | A word is accepted and words remain, or the last word is accepted while a new hit is present (the snapshot reloads). |
| ST_EMIT → ST_IDLE | The last word is accepted and no hit is present. |

Top module: `zs_stamp_packer`

## Requirements
- R1: A channel counts as hit when its toggle level differs from the level stored at the last accepting clock edge. A level held steady produces no word. `out_valid` rises only after a hit.
- R2: The coarse counter is 0 after reset and increments on every clock edge. A snapshot captures the counter value present at the loading edge.
- R3: A photon word's time field is `({coarse, fine} - ref) mod 2^23`. `ref` is the most recent sync timestamp, which is 0 before any sync.
- R4: A photon hit in the same cycle as a sync hit is referenced to that new sync. The sync word is channel 0, so it is emitted first, and it carries the absolute sync timestamp `{coarse, sync_fine}`.
- R5: A reference word's time is `{coarse - ref_coarse, 7'b0}`, where `ref_coarse` is the coarse part of the sync reference used in R3.
- R6: With `zs_en = 1`, only hit channels produce words, in strictly ascending channel index order.
- R7: With `zs_en = 0`, a cycle with any hit produces all 29 words in ascending order. Unhit channels have marker 0 and time 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` stays stable and `in_hold` is high. A toggle made during the stall is captured after the snapshot drains, using the coarse value at that loading edge.
- R9: After reset, `out_valid = 0` and `in_hold = 0`.
- R10: Word layout is as follows.

| Bits | Field |
|---|---|
| [30] | marker (1 = hit) |
| [29:25] | channel index: sync = 0, photon p = p+1, reference r = 26+r |
| [24:23] | kind: photon = 00, sync = 01, reference = 10 |
| [22:0] | time |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zs_en | input | 1 | 1 = emit only hit channels |
| sync_tog | input | 1 | Sync channel toggle level |
| sync_fine | input | 7 | Sync channel fine code |
| ph_tog | input | 25 | Photon channel toggle levels |
| ph_fine | input | 175 | Photon fine codes, photon p at bits [7p+6:7p] |
| ref_tog | input | 3 | Reference channel toggle levels |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | Word available |
| out_data | output | 31 | Packed timestamp word |
| in_hold | output | 1 | Inputs frozen; snapshot draining |

## Verification
The hardest situation to reach is a new toggle that lands while a snapshot is stalled. It must be neither lost nor stamped with the wrong coarse value. The bench holds `out_ready` low in the middle of a batch and toggles a second photon during the stall. It then releases ready on a known cycle and expects the second hit to carry the coarse count of that release edge, in the word that immediately follows.

A second hard case is a photon whose fine code is below the sync fine code in the same cycle. This forces the modulo wrap of the start-stop difference. A vector built around a concurrent sync creates it.

// File: rtl/zsp_pkg.sv
package zsp_pkg;
    localparam int DEF_N_PH   = 25;
    localparam int DEF_N_REF  = 3;
    localparam int DEF_FINE_W = 7;
    localparam int DEF_CRS_W  = 16;

    typedef enum logic [1:0] {
        KIND_PHOTON = 2'b00,
        KIND_SYNC   = 2'b01,
        KIND_REF    = 2'b10
    } kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/zsp_toggle_detect.sv
module zsp_toggle_detect #(
    parameter int N = 29
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] hit
);
    logic [N-1:0] prev;

    for (genvar g = 0; g < N; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      prev[g] <= 1'b0;
            else if (accept) prev[g] <= lvl[g];
        end
        assign hit[g] = lvl[g] ^ prev[g];
    end

    // R8
    held_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(prev));
endmodule

// File: rtl/zsp_sequencer.sv
module zsp_sequencer #(
    parameter int N_CH   = 29,
    parameter int N_FINE = 26,
    parameter int FINE_W = 7,
    parameter int CRS_W  = 16,
    localparam int IDX_W  = $clog2(N_CH),
    localparam int TIME_W = CRS_W + FINE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH-1:0]          hit,
    input  logic [N_FINE*FINE_W-1:0] fine_all,
    input  logic [CRS_W-1:0]         crs,
    input  logic                     zs_en,
    input  logic                     out_ready,
    output logic                     accept,
    output logic                     valid,
    output logic [IDX_W-1:0]         cur_idx,
    output logic                     cur_marker,
    output logic [FINE_W-1:0]        cur_fine,
    output logic [CRS_W-1:0]         snap_crs,
    output logic [TIME_W-1:0]        snap_ref
);
    import zsp_pkg::*;

    seq_state_e state, nxt;
    logic [N_CH-1:0]   pend, hitmask, grant;
    logic [FINE_W-1:0] snap_fine [N_FINE];
    logic [TIME_W-1:0] last_sync, new_sync;
    logic              any_hit, fire, last, load;

    assign any_hit  = |hit;
    assign grant    = pend & (~pend + 1'b1);
    assign fire     = (state == ST_EMIT) && out_ready;
    assign last     = fire && ((pend & ~grant) == '0);
    assign accept   = (state == ST_IDLE) || last;
    assign load     = accept && any_hit;
    assign new_sync = {crs, fine_all[FINE_W-1:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (load) nxt = ST_EMIT;
            ST_EMIT: if (last && !any_hit) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // snapshot store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend      <= '0;
            hitmask   <= '0;
            snap_crs  <= '0;
            snap_ref  <= '0;
            last_sync <= '0;
            for (int i = 0; i < N_FINE; i++) snap_fine[i] <= '0;
        end else if (load) begin
            pend     <= zs_en ? hit : '1;
            hitmask  <= hit;
            snap_crs <= crs;
            for (int i = 0; i < N_FINE; i++)
                snap_fine[i] <= fine_all[i*FINE_W +: FINE_W];
            if (hit[0]) begin
                last_sync <= new_sync;
                snap_ref  <= new_sync;
            end else begin
                snap_ref  <= last_sync;
            end
        end else if (fire) begin
            pend <= pend & ~grant;
        end
    end

    // outputs
    always_comb begin
        valid      = (state == ST_EMIT);
        cur_idx    = '0;
        cur_fine   = '0;
        for (int i = N_CH - 1; i >= 0; i--)
            if (pend[i]) cur_idx = IDX_W'(i);
        for (int i = 0; i < N_FINE; i++)
            if (cur_idx == IDX_W'(i)) cur_fine = snap_fine[i];
        cur_marker = |(hitmask & grant);
    end

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !out_ready |=> valid && $stable(cur_idx) && $stable(snap_crs));

    // R6
    order_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !last |=> valid && (cur_idx > $past(cur_idx)));

    // R1
    load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> $past(any_hit));

    // R7
    valid_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (pend != '0));
endmodule

// File: rtl/zsp_word_fmt.sv
module zsp_word_fmt #(
    parameter int N_CH   = 29,
    parameter int N_PH   = 25,
    parameter int FINE_W = 7,
    parameter int CRS_W  = 16,
    localparam int IDX_W  = $clog2(N_CH),
    localparam int TIME_W = CRS_W + FINE_W,
    localparam int WORD_W = 1 + IDX_W + 2 + TIME_W
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              marker,
    input  logic [FINE_W-1:0] fine,
    input  logic [CRS_W-1:0]  crs,
    input  logic [TIME_W-1:0] ref_ts,
    output logic [WORD_W-1:0] word
);
    import zsp_pkg::*;

    kind_e             kind;
    logic [TIME_W-1:0] stamp, tval;
    logic [CRS_W-1:0]  crs_diff;

    assign stamp    = {crs, fine};
    assign crs_diff = crs - ref_ts[TIME_W-1 -: CRS_W];

    always_comb begin
        if (idx == '0)                    kind = KIND_SYNC;
        else if (idx <= IDX_W'(N_PH))     kind = KIND_PHOTON;
        else                              kind = KIND_REF;
        unique case (kind)
            KIND_SYNC:   tval = stamp;
            KIND_PHOTON: tval = stamp - ref_ts;
            default:     tval = {crs_diff, {FINE_W{1'b0}}};
        endcase
        if (!marker) tval = '0;
        word = {marker, idx, kind, tval};
    end
endmodule

// File: rtl/zs_stamp_packer.sv
module zs_stamp_packer #(
    parameter int N_PH   = zsp_pkg::DEF_N_PH,
    parameter int N_REF  = zsp_pkg::DEF_N_REF,
    parameter int FINE_W = zsp_pkg::DEF_FINE_W,
    parameter int CRS_W  = zsp_pkg::DEF_CRS_W,
    localparam int N_FINE = 1 + N_PH,
    localparam int N_CH   = N_FINE + N_REF,
    localparam int IDX_W  = $clog2(N_CH),
    localparam int TIME_W = CRS_W + FINE_W,
    localparam int WORD_W = 1 + IDX_W + 2 + TIME_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   zs_en,
    input  logic                   sync_tog,
    input  logic [FINE_W-1:0]      sync_fine,
    input  logic [N_PH-1:0]        ph_tog,
    input  logic [N_PH*FINE_W-1:0] ph_fine,
    input  logic [N_REF-1:0]       ref_tog,
    input  logic                   out_ready,
    output logic                   out_valid,
    output logic [WORD_W-1:0]      out_data,
    output logic                   in_hold
);
    logic [CRS_W-1:0]  crs, snap_crs;
    logic [N_CH-1:0]   hit;
    logic              accept, cur_marker;
    logic [IDX_W-1:0]  cur_idx;
    logic [FINE_W-1:0] cur_fine;
    logic [TIME_W-1:0] snap_ref;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crs <= '0;
        else        crs <= crs + 1'b1;
    end

    zsp_toggle_detect #(.N(N_CH)) u_detect (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .lvl({ref_tog, ph_tog, sync_tog}), .hit(hit)
    );

    zsp_sequencer #(.N_CH(N_CH), .N_FINE(N_FINE), .FINE_W(FINE_W), .CRS_W(CRS_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .hit(hit), .fine_all({ph_fine, sync_fine}),
        .crs(crs), .zs_en(zs_en), .out_ready(out_ready), .accept(accept),
        .valid(out_valid), .cur_idx(cur_idx), .cur_marker(cur_marker),
        .cur_fine(cur_fine), .snap_crs(snap_crs), .snap_ref(snap_ref)
    );

    zsp_word_fmt #(.N_CH(N_CH), .N_PH(N_PH), .FINE_W(FINE_W), .CRS_W(CRS_W)) u_fmt (
        .idx(cur_idx), .marker(cur_marker), .fine(cur_fine),
        .crs(snap_crs), .ref_ts(snap_ref), .word(out_data)
    );

    assign in_hold = !accept;

    // R9
    hold_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold |-> out_valid);
endmodule

// File: tb/test_zs_stamp_packer.sv
module test_zs_stamp_packer;
    localparam int NP = 25, NR = 3, FW = 7, CW = 16, TW = CW + FW, WW = 31;

    logic           clk = 1'b0, rst_n = 1'b0, zs_en = 1'b1, out_ready = 1'b1;
    logic           sync_tog = 1'b0;
    logic [FW-1:0]  sync_fine = '0;
    logic [NP-1:0]  ph_tog = '0;
    logic [NP*FW-1:0] ph_fine = '0;
    logic [NR-1:0]  ref_tog = '0;
    logic           out_valid, in_hold;
    logic [WW-1:0]  out_data;

    int tests = 0, fails = 0;
    logic [CW-1:0] tb_crs;
    logic [TW-1:0] tb_last = '0;

    always #2.5 clk = ~clk;

    always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) tb_crs <= '0; else tb_crs <= tb_crs + 1'b1;

    zs_stamp_packer i_zs_stamp_packer (
        .clk(clk), .rst_n(rst_n), .zs_en(zs_en), .sync_tog(sync_tog),
        .sync_fine(sync_fine), .ph_tog(ph_tog), .ph_fine(ph_fine),
        .ref_tog(ref_tog), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .in_hold(in_hold)
    );

    // vector: {zs, sync, ref[2:0], ph[24:0], fine_base[6:0]}
    localparam logic [36:0] VEC [8] = '{
        {1'b1, 1'b0, 3'b000, 25'h0000001, 7'd10},
        {1'b1, 1'b1, 3'b000, 25'h0000000, 7'd33},
        {1'b1, 1'b0, 3'b000, 25'h1000021, 7'd5},
        {1'b1, 1'b1, 3'b001, 25'h0000003, 7'd50},
        {1'b1, 1'b0, 3'b110, 25'h0000000, 7'd0},
        {1'b0, 1'b0, 3'b000, 25'h0000010, 7'd77},
        {1'b1, 1'b1, 3'b101, 25'h1FFFFFF, 7'd120},
        {1'b0, 1'b1, 3'b010, 25'h0400000, 7'd9}
    };

    function automatic logic [FW-1:0] phf(int p, logic [FW-1:0] b);
        return FW'(int'(b) + 37 * p + 90);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [WW-1:0] act,
                       input logic [WW-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] exp_word(int ch, logic mk, logic [CW-1:0] cap,
                                               logic [FW-1:0] f, logic [TW-1:0] r);
        logic [1:0] kind;
        logic [TW-1:0] t;
        logic [CW-1:0] cd;
        cd = cap - r[TW-1 -: CW];
        if (ch == 0) begin kind = 2'b01; t = {cap, f}; end
        else if (ch <= NP) begin kind = 2'b00; t = {cap, f} - r; end
        else begin kind = 2'b10; t = {cd, {FW{1'b0}}}; end
        if (!mk) t = '0;
        return {mk, 5'(ch), kind, t};
    endfunction

    // called at a negedge; applies one batch and checks the whole word sequence
    task automatic run_batch(input logic [36:0] v);
        logic zs, s;
        logic [NR-1:0] rm;
        logic [NP-1:0] pm;
        logic [FW-1:0] fb;
        logic [CW-1:0] cap;
        logic [TW-1:0] r;
        logic [28:0] hm;
        {zs, s, rm, pm, fb} = v;
        cap = tb_crs;
        zs_en = zs;
        sync_fine = fb;
        for (int p = 0; p < NP; p++) ph_fine[p*FW +: FW] = phf(p, fb);
        sync_tog ^= s; ph_tog ^= pm; ref_tog ^= rm;
        hm = {rm, pm, s};
        r = s ? {cap, fb} : tb_last;
        if (s) tb_last = {cap, fb};
        @(negedge clk);
        for (int ch = 0; ch < 29; ch++) begin
            if (zs && !hm[ch]) continue;
            begin
                logic [WW-1:0] e;
                e = exp_word(ch, hm[ch], cap,
                             (ch == 0) ? fb : (ch <= NP ? phf(ch - 1, fb) : '0), r);
                // R3 R4 R5 R6 R7 R10: word content and order
                chk(out_valid && out_data == e, "R3/R4/R5/R6/R7/R10 word", out_data, e);
            end
            @(negedge clk);
        end
        // R6: batch ends with no extra word
        chk(!out_valid, "R6 batch end", WW'(out_valid), '0);
    endtask

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [CW-1:0] cap1, cap2;
        logic [WW-1:0] e1, e2, held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        chk(!out_valid, "R9 valid after reset", WW'(out_valid), '0);
        chk(!in_hold, "R9 hold after reset", WW'(in_hold), '0);
        // R2: counter runs from 0 each edge after reset
        chk(tb_crs == CW'(1), "R2 coarse origin", WW'(tb_crs), WW'(1));

        foreach (VEC[k]) run_batch(VEC[k]);

        // R1: steady levels give no words
        repeat (4) begin
            @(negedge clk);
            chk(!out_valid, "R1 steady no word", WW'(out_valid), '0);
        end

        // R8: stall with a toggle arriving during it
        zs_en = 1'b1;
        out_ready = 1'b0;
        for (int p = 0; p < NP; p++) ph_fine[p*FW +: FW] = FW'(p + 3);
        cap1 = tb_crs;
        ph_tog[0] ^= 1'b1;
        e1 = exp_word(1, 1'b1, cap1, FW'(3), tb_last);
        @(negedge clk);
        chk(out_valid && out_data == e1, "R8 first word", out_data, e1);
        chk(in_hold, "R8 hold during stall", WW'(in_hold), WW'(1));
        held = out_data;
        ph_tog[2] ^= 1'b1;
        repeat (2) begin
            @(negedge clk);
            chk(out_valid && out_data == held, "R8 stable while stalled", out_data, held);
            chk(in_hold, "R8 hold during stall", WW'(in_hold), WW'(1));
        end
        out_ready = 1'b1;
        cap2 = tb_crs;
        e2 = exp_word(3, 1'b1, cap2, FW'(5), tb_last);
        @(negedge clk);
        // R8 R2: pending toggle captured at the release edge
        chk(out_valid && out_data == e2, "R8 deferred hit", out_data, e2);
        @(negedge clk);
        chk(!out_valid, "R8 drained", WW'(out_valid), '0);
        chk(!in_hold, "R9 hold idle", WW'(in_hold), '0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule